// File: doc/BRIEF.md
# I2C Dual-Wiper Register Target

This block is the serial front end of a two-channel, 256-step digital resistor controller. It sits on a two-wire I2C bus as a target. The system clock samples SCL and SDA, and the block drives SDA only as an open-drain pull-down through an enable output. A controller writes one transaction of three bytes: the target address, an instruction byte and an 8-bit wiper position. The instruction byte chooses which of the two wiper registers the position goes to and sets or clears a shutdown flag.

A read has no pointer byte. After the address byte, the block returns the register of whichever channel the most recent instruction byte picked. The 7-bit address has a fixed upper part. The two low bits come either from two strap pins or from a constant, chosen by a parameter. With the strap pins, up to four of these blocks can share one bus.

The two wiper values and the shutdown flag are presented as plain outputs. These outputs feed the analog side.

Top module: `i2c_wiper_target`

## Requirements
- R1: The block responds only to the 7-bit address made of ADDR_HI (default 01011) followed by two low bits. The low bits are strap_i[1:0] when STRAP_EN=1 and FIXED_LO (default 11) when STRAP_EN=0. Bit 0 of the first byte after START is the direction: 0 means write, 1 means read.
- R2: In a write, the block acknowledges the address byte, the instruction byte and the data byte. It does so by asserting sda_oe_o (1 = pull SDA low) during the ninth SCL clock of each byte, and it asserts sda_oe_o only in acknowledge or read-data phases.
- R3: Bit 7 of the instruction byte selects the channel (0 = wiper 0, 1 = wiper 1) and bit 6 is the shutdown value; bits 5..0 are ignored. The selection and shutdown_o take effect when the instruction byte is acknowledged, before any data byte arrives.
- R4: The data byte, received MSB first, is loaded into the wiper register of the selected channel when it is acknowledged. The other wiper keeps its value.
- R5: In a read, after the address acknowledge, the block shifts out the selected channel's 8-bit register MSB first, one byte per read. SDA changes only while SCL is low.
- R6: When the address does not match, the block does not acknowledge and ignores all traffic until the next START or STOP.
- R7: A STOP that arrives before the data byte completes leaves both wiper registers unchanged.
- R8: A repeated START in the middle of a transaction restarts address matching without a STOP.
- R9: After reset, both wipers hold 0x80, shutdown_o is 0, channel 0 is selected, and SDA is released.
- R10: Bytes that follow the data byte of a write are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 2 | Address pins giving the two low address bits (used when STRAP_EN=1) |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| wiper0_o | output | 8 | Position register of channel 0 |
| wiper1_o | output | 8 | Position register of channel 1 |
| shutdown_o | output | 1 | Shutdown flag from the last acknowledged instruction byte |

## Verification
The bench builds two copies on one wired-AND bus.
- One copy uses STRAP_EN=1 with strap_i tied to 10, which gives address 0x2E.
- The other copy uses STRAP_EN=0 and the default FIXED_LO, which gives address 0x2F.

Every transaction aimed at one copy is foreign-address traffic for the other, so the ignore path is exercised all the time. A write to the neighbouring strap code 0x2C reaches neither copy, and a read from that address must return the released-bus value 0xFF.

// File: rtl/i2c_wiper_pkg.sv
package i2c_wiper_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_o      = sync_q.scl_pipe[STAGES-1];
    assign sda_o      = sync_q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_o & sync_q.scl_prev;
    // bus conditions: SDA moves while SCL stays high
    assign start_o    = scl_o & sync_q.scl_prev & ~sda_o & sync_q.sda_prev;
    assign stop_o     = scl_o & sync_q.scl_prev & sda_o & ~sync_q.sda_prev;
endmodule

// File: rtl/i2c_wiper_regs.sv
module i2c_wiper_regs
    import i2c_wiper_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_POS = 8'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          instr_we_i,
    input  logic                          instr_sel_i,
    input  logic                          instr_sd_i,
    input  logic                          data_we_i,
    input  logic [BYTE_W-1:0]             data_i,
    output logic [NUM_CH-1:0][BYTE_W-1:0] wiper_o,
    output logic                          shutdown_o,
    output logic [BYTE_W-1:0]             rd_data_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][BYTE_W-1:0] wiper;
        logic                          sel;
        logic                          sd;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (instr_we_i) begin
            regs_d.sel = instr_sel_i;
            regs_d.sd  = instr_sd_i;
        end
        if (data_we_i) begin
            regs_d.wiper[regs_q.sel] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.wiper <= {NUM_CH{RESET_POS}};
            regs_q.sel   <= 1'b0;
            regs_q.sd    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wiper_o    = regs_q.wiper;
    assign shutdown_o = regs_q.sd;
    assign rd_data_o  = regs_q.wiper[regs_q.sel];
endmodule

// File: rtl/i2c_wiper_proto.sv
module i2c_wiper_proto
    import i2c_wiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [6:0]        own_addr_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              instr_we_o,
    output logic              instr_sel_o,
    output logic              instr_sd_o,
    output logic              data_we_o,
    output logic [BYTE_W-1:0] data_o,
    output tgt_state_e        state_o,
    output logic [BYTE_W-1:0] shift_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e        state;
        logic [BYTE_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              rw;
        logic              oe;
    } proto_t;

    proto_t pr_d, pr_q;
    logic   byte_done;

    assign byte_done = scl_fall_i && (pr_q.cnt == LAST_BIT);

    always_comb begin
        pr_d       = pr_q;
        instr_we_o = 1'b0;
        data_we_o  = 1'b0;
        if (start_i) begin
            pr_d.state = ST_ADDR;
            pr_d.cnt   = '0;
            pr_d.oe    = 1'b0;
        end else if (stop_i) begin
            pr_d.state = ST_IDLE;
            pr_d.oe    = 1'b0;
        end else begin
            case (pr_q.state)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise_i && pr_q.cnt != LAST_BIT) begin
                        pr_d.shift = {pr_q.shift[BYTE_W-2:0], sda_i};
                        pr_d.cnt   = pr_q.cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        pr_d.cnt = '0;
                        pr_d.oe  = 1'b1;
                        if (pr_q.state == ST_ADDR) begin
                            if (pr_q.shift[BYTE_W-1:1] == own_addr_i) begin
                                pr_d.state = ST_ADDR_ACK;
                                pr_d.rw    = pr_q.shift[0];
                            end else begin
                                pr_d.state = ST_IGNORE;
                                pr_d.oe    = 1'b0;
                            end
                        end else if (pr_q.state == ST_INSTR) begin
                            pr_d.state = ST_INSTR_ACK;
                            instr_we_o = 1'b1;
                        end else begin
                            pr_d.state = ST_DATA_ACK;
                            data_we_o  = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        if (pr_q.rw) begin
                            pr_d.state = ST_RD_BYTE;
                            pr_d.shift = rd_data_i;
                            pr_d.oe    = ~rd_data_i[BYTE_W-1];
                        end else begin
                            pr_d.state = ST_INSTR;
                            pr_d.oe    = 1'b0;
                        end
                    end
                end
                ST_INSTR_ACK: begin
                    if (scl_fall_i) begin
                        pr_d.state = ST_DATA;
                        pr_d.oe    = 1'b0;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall_i) begin
                        pr_d.state = ST_IGNORE;
                        pr_d.oe    = 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise_i) begin
                        pr_d.cnt = pr_q.cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        pr_d.state = ST_IGNORE;
                        pr_d.oe    = 1'b0;
                    end else if (scl_fall_i) begin
                        pr_d.shift = {pr_q.shift[BYTE_W-2:0], 1'b0};
                        pr_d.oe    = ~pr_q.shift[BYTE_W-2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q.state <= ST_IDLE;
            pr_q.shift <= '0;
            pr_q.cnt   <= '0;
            pr_q.rw    <= 1'b0;
            pr_q.oe    <= 1'b0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign sda_oe_o    = pr_q.oe;
    assign instr_sel_o = pr_q.shift[BYTE_W-1];
    assign instr_sd_o  = pr_q.shift[BYTE_W-2];
    assign data_o      = pr_q.shift;
    assign state_o     = pr_q.state;
    assign shift_o     = pr_q.shift;
endmodule

// File: rtl/i2c_wiper_target.sv
module i2c_wiper_target
    import i2c_wiper_pkg::*;
#(
    parameter logic [4:0]        ADDR_HI     = 5'b01011,
    parameter bit                STRAP_EN    = 1'b1,
    parameter logic [1:0]        FIXED_LO    = 2'b11,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] RESET_POS   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] wiper0_o,
    output logic [BYTE_W-1:0] wiper1_o,
    output logic              shutdown_o
);
    logic                          scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
    logic [6:0]                    own_addr;
    logic                          instr_we, instr_sel, instr_sd, data_we;
    logic [BYTE_W-1:0]             data_w, rd_data, shift_w;
    logic [NUM_CH-1:0][BYTE_W-1:0] wiper_w;
    tgt_state_e                    state_w;

    assign own_addr = {ADDR_HI, (STRAP_EN ? strap_i : FIXED_LO)};

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_wiper_proto proto_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .sda_i       (sda_s),
        .start_i     (start_w),
        .stop_i      (stop_w),
        .own_addr_i  (own_addr),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe_o),
        .instr_we_o  (instr_we),
        .instr_sel_o (instr_sel),
        .instr_sd_o  (instr_sd),
        .data_we_o   (data_we),
        .data_o      (data_w),
        .state_o     (state_w),
        .shift_o     (shift_w)
    );

    i2c_wiper_regs #(.RESET_POS(RESET_POS)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_we_i  (instr_we),
        .instr_sel_i (instr_sel),
        .instr_sd_i  (instr_sd),
        .data_we_i   (data_we),
        .data_i      (data_w),
        .wiper_o     (wiper_w),
        .shutdown_o  (shutdown_o),
        .rd_data_o   (rd_data)
    );

    assign wiper0_o = wiper_w[0];
    assign wiper1_o = wiper_w[1];
endmodule

// File: rtl/i2c_wiper_target_chk.sv
module i2c_wiper_target_chk
    import i2c_wiper_pkg::*;
#(
    parameter logic [4:0] ADDR_HI  = 5'b01011,
    parameter bit         STRAP_EN = 1'b1,
    parameter logic [1:0] FIXED_LO = 2'b11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        strap_i,
    input logic              sda_oe_o,
    input logic [BYTE_W-1:0] wiper0_o,
    input logic [BYTE_W-1:0] wiper1_o,
    input logic              shutdown_o,
    input tgt_state_e        state_w,
    input logic [BYTE_W-1:0] shift_w,
    input logic              scl_s,
    input logic              start_w,
    input logic              stop_w
);
    logic [6:0] exp_addr;
    assign exp_addr = STRAP_EN ? {ADDR_HI, strap_i} : {ADDR_HI, FIXED_LO};

    assert_addr_ack_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && state_w == ST_ADDR_ACK) |-> (shift_w[7:1] == exp_addr));

    assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_w == ST_ADDR_ACK || state_w == ST_INSTR_ACK ||
                      state_w == ST_DATA_ACK || state_w == ST_RD_BYTE));

    assert_sd_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shutdown_o) |-> state_w == ST_INSTR_ACK);

    assert_wiper_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wiper0_o) || !$stable(wiper1_o)) |-> state_w == ST_DATA_ACK);

    assert_hold_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_w) && !$past(stop_w)) |-> $stable(sda_oe_o));

    assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (state_w == ST_IDLE && !sda_oe_o));

    assert_restart_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (state_w == ST_ADDR && !sda_oe_o));
endmodule

bind i2c_wiper_target i2c_wiper_target_chk #(
    .ADDR_HI  (ADDR_HI),
    .STRAP_EN (STRAP_EN),
    .FIXED_LO (FIXED_LO)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (strap_i),
    .sda_oe_o   (sda_oe_o),
    .wiper0_o   (wiper0_o),
    .wiper1_o   (wiper1_o),
    .shutdown_o (shutdown_o),
    .state_w    (state_w),
    .shift_w    (shift_w),
    .scl_s      (scl_s),
    .start_w    (start_w),
    .stop_w     (stop_w)
);

// File: tb/i2c_wiper_target_tb_top.sv
`timescale 1ns/1ps
module i2c_wiper_target_tb_top;
    localparam int Q = 10;
    localparam logic [6:0] ADDR_A = 7'h2E;
    localparam logic [6:0] ADDR_B = 7'h2F;
    localparam logic [6:0] ADDR_X = 7'h30;
    localparam logic [6:0] ADDR_N = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    logic oe_a, oe_b, sd_a, sd_b, sda_bus;
    logic [7:0] w0_a, w1_a, w0_b, w1_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = ~(sda_m_low | oe_a | oe_b);

    i2c_wiper_target #(.STRAP_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(2'b10),
        .sda_oe_o(oe_a), .wiper0_o(w0_a), .wiper1_o(w1_a), .shutdown_o(sd_a)
    );

    i2c_wiper_target #(.STRAP_EN(1'b0)) dut_fix_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(2'b00),
        .sda_oe_o(oe_b), .wiper0_o(w0_b), .wiper1_o(w1_b), .shutdown_o(sd_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m_low = 1'b0; scl_m = 1'b1; wq(Q);
        sda_m_low = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_rstart();
        sda_m_low = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m_low = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m_low = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m_low = 1'b0; wq(Q);
    endtask

    task automatic m_bit(input bit drive_low, output bit val, output bit held);
        bit s0;
        sda_m_low = drive_low; wq(Q);
        scl_m = 1'b1; wq(Q);
        s0 = sda_bus; wq(Q);
        val = sda_bus;
        held = (s0 == val);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_send(input logic [7:0] b, output bit acked);
        bit v, h;
        for (int i = 7; i >= 0; i--) m_bit(~b[i], v, h);
        m_bit(1'b0, v, h);
        acked = ~v;
    endtask

    task automatic m_read(output logic [7:0] d, output bit stable);
        bit v, h;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b0, v, h);
            d[i] = v;
            stable &= h;
        end
        m_bit(1'b0, v, h);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] ins, input logic [7:0] dat,
                          output bit k0, output bit k1, output bit k2);
        m_start();
        m_send({a, 1'b0}, k0);
        m_send(ins, k1);
        m_send(dat, k2);
        m_stop();
    endtask

    task automatic rd_txn(input logic [6:0] a, output logic [7:0] d, output bit k, output bit st);
        m_start();
        m_send({a, 1'b1}, k);
        m_read(d, st);
        m_stop();
    endtask

    task automatic t_reset();
        chk("R9 w0 reset", w0_a, 8'h80);
        chk("R9 w1 reset", w1_a, 8'h80);
        chk("R9 sd reset", sd_a, 0);
        chk("R9 fixed w0 reset", w0_b, 8'h80);
        chk("R9 sda released", {oe_a, oe_b}, 0);
    endtask

    task automatic t_reset_read();
        logic [7:0] d; bit k, st;
        rd_txn(ADDR_A, d, k, st);
        chk("R5 read addr ack", k, 1);
        chk("R9 read ch0 after reset", d, 8'h80);
        chk("R5 sda stable while scl high", st, 1);
    endtask

    task automatic t_write_ch0();
        bit k0, k1, k2;
        wr_txn(ADDR_A, 8'h00, 8'h3C, k0, k1, k2);
        chk("R2 three acks", {k0, k1, k2}, 3'b111);
        chk("R4 w0 loaded", w0_a, 8'h3C);
        chk("R4 w1 untouched", w1_a, 8'h80);
        chk("R1 other address unaffected", w0_b, 8'h80);
    endtask

    task automatic t_write_ch1_dontcare();
        bit k0, k1, k2;
        wr_txn(ADDR_A, 8'hBF, 8'hA5, k0, k1, k2);
        chk("R3 w1 via bit7 with junk low bits", w1_a, 8'hA5);
        chk("R3 sd from bit6=0", sd_a, 0);
        chk("R4 w0 kept", w0_a, 8'h3C);
    endtask

    task automatic t_shutdown_timing();
        bit k0, k1, k2;
        m_start();
        m_send({ADDR_A, 1'b0}, k0);
        m_send(8'h40, k1);
        chk("R3 sd set at instruction ack", sd_a, 1);
        chk("R4 w0 not yet loaded", w0_a, 8'h3C);
        m_send(8'h01, k2);
        m_stop();
        chk("R4 w0 loaded after data", w0_a, 8'h01);
    endtask

    task automatic t_read_sel();
        logic [7:0] d; bit k, st, k0, k1, k2;
        rd_txn(ADDR_A, d, k, st);
        chk("R5 read ch0", d, 8'h01);
        wr_txn(ADDR_A, 8'h80, 8'hFF, k0, k1, k2);
        chk("R3 sd cleared", sd_a, 0);
        rd_txn(ADDR_A, d, k, st);
        chk("R5 read ch1", d, 8'hFF);
        chk("R5 stable", st, 1);
    endtask

    task automatic t_fixed();
        bit k0, k1, k2;
        wr_txn(ADDR_B, 8'h80, 8'h5A, k0, k1, k2);
        chk("R1 fixed address acks", {k0, k1, k2}, 3'b111);
        chk("R1 fixed w1", w1_b, 8'h5A);
        chk("R1 strap dev w1 kept", w1_a, 8'hFF);
    endtask

    task automatic t_mismatch();
        bit k0, k1, k2;
        logic [7:0] d; bit k, st;
        wr_txn(ADDR_X, 8'h00, 8'h12, k0, k1, k2);
        chk("R6 no acks", {k0, k1, k2}, 3'b000);
        chk("R6 A w0 kept", w0_a, 8'h01);
        chk("R6 B w0 kept", w0_b, 8'h80);
        rd_txn(ADDR_N, d, k, st);
        chk("R6 neighbour strap code no ack", k, 0);
        chk("R6 read from nobody", d, 8'hFF);
    endtask

    task automatic t_cut();
        bit k0, k1;
        logic [7:0] d; bit k, st;
        m_start();
        m_send({ADDR_A, 1'b0}, k0);
        m_send(8'h00, k1);
        m_stop();
        chk("R7 w0 kept after early stop", w0_a, 8'h01);
        chk("R7 w1 kept after early stop", w1_a, 8'hFF);
        rd_txn(ADDR_A, d, k, st);
        chk("R7 channel moved to 0", d, 8'h01);
    endtask

    task automatic t_rstart();
        bit k0, k1, k2;
        logic [7:0] d; bit st;
        m_start();
        m_send({ADDR_A, 1'b0}, k0);
        m_send(8'hC0, k1);
        m_rstart();
        m_send({ADDR_A, 1'b1}, k2);
        m_read(d, st);
        m_stop();
        chk("R8 read after repeated start acked", k2, 1);
        chk("R8 read ch1", d, 8'hFF);
        chk("R3 sd set", sd_a, 1);
        m_start();
        m_send({ADDR_X, 1'b0}, k0);
        m_rstart();
        m_send({ADDR_A, 1'b0}, k1);
        m_send(8'h00, k2);
        m_send(8'h77, k2);
        m_stop();
        chk("R8 ack after restart from ignore", {k0, k1}, 2'b01);
        chk("R8 w0 written", w0_a, 8'h77);
        chk("R8 sd cleared", sd_a, 0);
    endtask

    task automatic t_extra();
        bit k0, k1, k2, k3;
        m_start();
        m_send({ADDR_A, 1'b0}, k0);
        m_send(8'h80, k1);
        m_send(8'h10, k2);
        m_send(8'h99, k3);
        m_stop();
        chk("R10 extra byte not acked", {k0, k1, k2, k3}, 4'b1110);
        chk("R10 w1 holds data byte", w1_a, 8'h10);
        chk("R10 w0 untouched", w0_a, 8'h77);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(10);
        t_reset();
        t_reset_read();
        t_write_ch0();
        t_write_ch1_dontcare();
        t_shutdown_timing();
        t_read_sel();
        t_fixed();
        t_mismatch();
        t_cut();
        t_rstart();
        t_extra();
        wq(20);
        finish_run();
    end
endmodule